// File: doc/BRIEF.md
# Stepped-Ratio Serial Clock Generator

This block derives the serial clock of an SPI controller from the reference clock. A 5-bit select code picks the divide ratio from a fixed ladder. On that ladder, successive ratios grow by 4/3 and then by 3/2 in turn, so the values run 3, 4, 6, 8, 12 and onward up to 1024. Because the ratio is not restricted to powers of two, software can land closer to a target bit rate. Software works out the code; this block only turns a code into a clock.

Alongside the serial clock, the block drives a one-cycle edge strobe. The shift engine uses that strobe to decide when to sample and when to shift. An active flag shows that a clock is being produced.

The block reads the code at the start of every period, so changing it never cuts a period short. Dropping the enable stops the clock immediately. While no clock runs, the output sits at the idle level given by the polarity input. A parameter sets the highest legal code, so a smaller variant can cap the ladder lower.

Top module: `sclk_ladder_div`

## Requirements
- R1: With an effective code c between 2 and MAX_CODE, one serial clock period lasts 2^(c/2+1) reference cycles when c is even and 3·2^((c-1)/2) cycles when c is odd (code 2 → 4, 3 → 6, 18 → 1024).
- R2: Each period starts with the active level (the inverse of cpol) for floor(ratio/2) cycles, then holds the idle level (equal to cpol) for the remaining cycles. For ratio 3 this gives 1 active cycle and 2 idle cycles.
- R3: Code 0 never starts a clock: active stays 0 and sclk stays at cpol.
- R4: Code 1 gives ratio 3 only while allowDiv3 is 1. While allowDiv3 is 0, code 1 behaves like code 0.
- R5: A code above MAX_CODE is treated as MAX_CODE. For example, code 31 gives ratio 1024 with MAX_CODE=18 and ratio 512 with MAX_CODE=16.
- R6: While active, edgeTick is 1 in exactly those cycles in which sclk has just changed level, so there is one pulse per serial clock edge.
- R7: A code change made during a period does not alter that period. The new code takes effect at the next period start.
- R8: Whenever active is 0, sclk equals cpol in the same cycle. Deasserting enable makes active 0 one clock edge later.
- R9: When active is 0 and enable is sampled 1 with a valid code, the next cycle has active=1, edgeTick=1 and sclk at the active level.
- R10: During reset, active and edgeTick are 0 and sclk equals cpol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; 0 stops the clock at once |
| code | input | CODE_W | Ladder select code |
| allowDiv3 | input | 1 | Permits code 1 (ratio 3) |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| edgeTick | output | 1 | One-cycle pulse in the cycle after each sclk edge |
| active | output | 1 | Clock generation in progress |

## Verification
The bench measures the active-phase length and the full period for codes drawn at random across the whole ladder and above it, and compares them with a ratio it builds by repeated 4/3 and 3/2 steps. A wrong ladder entry or an off-by-one counter compare would show up as a period one cycle short or long. The ratio-3 case catches a duty split that rounds the wrong way. Codes 0 and 1 are probed with and without the divide-by-3 permission, and a design that does not gate them would start toggling. A code change in mid-period, an abort in the active phase and the clamp on a low-limit instance show, respectively, a shortened first period, a lingering active level, or a 1024 ratio where 512 is due.

// File: rtl/sclk_ladder_pkg.sv
package sclk_ladder_pkg;

  // Strobes from the control FSM to the counter datapath; at most one is set.
  typedef struct packed {
    logic load;     // begin a period: latch lengths, enter active level
    logic midFlip;  // end of active phase: go to idle level
    logic advance;  // plain count
    logic halt;     // stop: clear counter, force idle level
  } ladderStrobe_t;

endpackage

// File: rtl/sclk_ladder_ctrl.sv
module sclk_ladder_ctrl
  import sclk_ladder_pkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int MAX_CODE = 18,
  parameter int CNT_W    = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CODE_W-1:0] code,
  input  logic              allowDiv3,
  input  logic              atMid,
  input  logic              atEnd,
  output ladderStrobe_t     strobe,
  output logic [CNT_W-1:0]  ratio,
  output logic              active
);

  localparam logic [CODE_W-1:0] CODE_LIMIT = CODE_W'(MAX_CODE);

  // Ratio ladder built from constants, one entry per legal code.
  logic [CNT_W-1:0] ratioTab [0:MAX_CODE];

  for (genvar g = 0; g <= MAX_CODE; g++) begin : g_ladder
    localparam int RVAL = (g == 0) ? 0 :
                          ((g % 2) == 0) ? (1 << (g / 2 + 1)) :
                                           (3 << ((g - 1) / 2));
    assign ratioTab[g] = CNT_W'(RVAL);
  end

  logic [CODE_W-1:0] codeEff;
  logic              codeOk;
  logic              runQ;
  logic              runD;

  always_comb begin
    codeEff = (code > CODE_LIMIT) ? CODE_LIMIT : code;
    codeOk  = (codeEff >= CODE_W'(2)) || ((codeEff == CODE_W'(1)) && allowDiv3);
    ratio   = ratioTab[codeEff];
  end

  always_comb begin
    strobe = '0;
    if (!runQ) begin
      if (enable && codeOk) strobe.load = 1'b1;
      else                  strobe.halt = 1'b1;
    end else if (!enable) begin
      strobe.halt = 1'b1;
    end else if (atMid) begin
      strobe.midFlip = 1'b1;
    end else if (atEnd) begin
      if (codeOk) strobe.load = 1'b1;
      else        strobe.halt = 1'b1;
    end else begin
      strobe.advance = 1'b1;
    end
  end

  always_comb begin
    runD = runQ;
    if (strobe.load)      runD = 1'b1;
    else if (strobe.halt) runD = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runQ <= 1'b0;
    else       runQ <= runD;
  end

  assign active = runQ;

endmodule

// File: rtl/sclk_ladder_dp.sv
module sclk_ladder_dp
  import sclk_ladder_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  ladderStrobe_t    strobe,
  input  logic [CNT_W-1:0] ratio,
  input  logic             cpol,
  output logic             atMid,
  output logic             atEnd,
  output logic             sclk,
  output logic             edgeTick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] actLen;
  logic [CNT_W-1:0] perLen;
  logic             phaseQ;   // 1 = active level
  logic             tickQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      actLen <= '0;
      perLen <= '0;
      phaseQ <= 1'b0;
      tickQ  <= 1'b0;
    end else if (strobe.load) begin
      cnt    <= '0;
      actLen <= ratio >> 1;
      perLen <= ratio;
      phaseQ <= 1'b1;
      tickQ  <= 1'b1;
    end else if (strobe.midFlip) begin
      cnt    <= cnt + CNT_W'(1);
      phaseQ <= 1'b0;
      tickQ  <= 1'b1;
    end else if (strobe.advance) begin
      cnt    <= cnt + CNT_W'(1);
      tickQ  <= 1'b0;
    end else begin
      cnt    <= '0;
      phaseQ <= 1'b0;
      tickQ  <= 1'b0;
    end
  end

  assign atMid    = (cnt == actLen - CNT_W'(1));
  assign atEnd    = (cnt == perLen - CNT_W'(1));
  assign sclk     = cpol ^ phaseQ;
  assign edgeTick = tickQ;

endmodule

// File: rtl/sclk_ladder_div.sv
module sclk_ladder_div
  import sclk_ladder_pkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int MAX_CODE = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CODE_W-1:0] code,
  input  logic              allowDiv3,
  input  logic              cpol,
  output logic              sclk,
  output logic              edgeTick,
  output logic              active
);

  // Largest ratio is below 2^(MAX_CODE/2+2).
  localparam int CNT_W = MAX_CODE / 2 + 2;

  ladderStrobe_t    strobe;
  logic [CNT_W-1:0] ratio;
  logic             atMid;
  logic             atEnd;

  sclk_ladder_ctrl #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .code(code), .allowDiv3(allowDiv3),
    .atMid(atMid), .atEnd(atEnd), .strobe(strobe), .ratio(ratio), .active(active)
  );

  sclk_ladder_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ratio(ratio), .cpol(cpol),
    .atMid(atMid), .atEnd(atEnd), .sclk(sclk), .edgeTick(edgeTick)
  );

endmodule

// File: rtl/sclk_ladder_chk.sv
module sclk_ladder_chk #(
  parameter int CODE_W   = 5,
  parameter int MAX_CODE = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [CODE_W-1:0] code,
  input logic              allowDiv3,
  input logic              cpol,
  input logic              sclk,
  input logic              edgeTick,
  input logic              active
);

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (sclk == cpol));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !enable) |=> !active);

  // R6
  tick_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && $stable(cpol)) |-> (edgeTick == (sclk != $past(sclk))));

  // R3
  code0_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && code == '0) |=> !active);

  // R4
  div3_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && code == CODE_W'(1) && !allowDiv3) |=> !active);

  // R9
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && enable && code >= CODE_W'(2)) |=> (active && edgeTick && sclk != cpol));

  // R5
  clamp_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && enable && code > CODE_W'(MAX_CODE)) |=> active);

endmodule

bind sclk_ladder_div sclk_ladder_chk #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .code(code), .allowDiv3(allowDiv3),
  .cpol(cpol), .sclk(sclk), .edgeTick(edgeTick), .active(active)
);

// File: tb/test_sclk_ladder_div.sv
`timescale 1ns/1ps
module test_sclk_ladder_div;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [4:0] code = '0;
  logic       allowDiv3 = 1'b0;
  logic       cpol = 1'b0;
  logic       sclkM, tickM, actM;
  logic       sclkL, tickL, actL;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  sclk_ladder_div i_sclk_ladder_div (
    .clk(clk), .rstN(rstN), .enable(enable), .code(code), .allowDiv3(allowDiv3),
    .cpol(cpol), .sclk(sclkM), .edgeTick(tickM), .active(actM)
  );

  sclk_ladder_div #(.MAX_CODE(16)) i_sclk_ladder_div_lim (
    .clk(clk), .rstN(rstN), .enable(enable), .code(code), .allowDiv3(allowDiv3),
    .cpol(cpol), .sclk(sclkL), .edgeTick(tickL), .active(actL)
  );

  function automatic int expRatio(input int c, input int maxC);
    int cc = (c > maxC) ? maxC : c;
    int r = 3;
    for (int i = 2; i <= cc; i++) begin
      if ((i % 2) == 0) r = r * 4 / 3;
      else              r = r * 3 / 2;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  function automatic logic selS(input bit lim); return lim ? sclkL : sclkM; endfunction
  function automatic logic selT(input bit lim); return lim ? tickL : tickM; endfunction
  function automatic logic selA(input bit lim); return lim ? actL : actM; endfunction

  // Stop, set up, enable; check the start cycle (R9).
  task automatic startRun(input bit lim, input logic [4:0] c, input logic pol);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); code = c; cpol = pol; enable = 1'b1;
    @(negedge clk);
    check(selA(lim) && selT(lim) && (selS(lim) != pol), "R9 start", selA(lim), 1);
  endtask

  // Measure one period from the current leading edge to the next (R1, R2, R6, R7).
  task automatic runPeriod(input bit lim, input int chgAt, input logic [4:0] chgCode,
                           output int actN, output int perN, output int glitches);
    logic prev = selS(lim);
    actN = -1; perN = -1; glitches = 0;
    for (int n = 1; n <= 3000; n++) begin
      @(negedge clk);
      if (n == chgAt) code = chgCode;
      if ((selS(lim) != prev) != selT(lim)) glitches++;
      prev = selS(lim);
      if (selT(lim) && selS(lim) == cpol) actN = n;
      if (selT(lim) && selS(lim) != cpol) begin
        perN = n;
        break;
      end
    end
  endtask

  task automatic measureCode(input bit lim, input int c, input logic pol, input string req);
    int a, p, g;
    int r = expRatio(c, lim ? 16 : 18);
    startRun(lim, c[4:0], pol);
    runPeriod(lim, 0, '0, a, p, g);
    check(p == r, {req, " R1 period"}, p, r);
    check(a == r / 2, {req, " R2 active phase"}, a, r / 2);
    check(g == 0, {req, " R6 tick per edge"}, g, 0);
  endtask

  task automatic expectIdle(input int cycles, input string req);
    int ticks = 0;
    int bad = 0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (tickM) ticks++;
      if (actM || sclkM != cpol) bad++;
    end
    check(ticks == 0 && bad == 0, req, ticks + bad, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=expired expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : stim
    int a, p, g;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10
    check(!actM && !tickM && sclkM == 1'b0, "R10 reset state", {actM, tickM, sclkM}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: code 0 never starts
    code = 5'd0; enable = 1'b1;
    expectIdle(40, "R3 code 0 idle");

    // R4: code 1 gated by allowDiv3
    code = 5'd1; allowDiv3 = 1'b0;
    expectIdle(40, "R4 code 1 without permission");
    allowDiv3 = 1'b1;
    measureCode(1'b0, 1, 1'b0, "R4 ratio 3");
    runPeriod(1'b0, 0, '0, a, p, g);
    check(p == 3 && a == 1, "R2 ratio 3 second period", p * 10 + a, 31);
    allowDiv3 = 1'b0;

    // R8: idle level follows polarity immediately
    @(negedge clk); enable = 1'b0;
    @(negedge clk); cpol = 1'b1;
    @(negedge clk);
    check(sclkM == 1'b1 && !actM, "R8 idle at cpol=1", sclkM, 1);
    cpol = 1'b0;
    @(negedge clk);
    check(sclkM == 1'b0, "R8 idle at cpol=0", sclkM, 0);

    // R1/R2 directed ends of ladder
    measureCode(1'b0, 2, 1'b0, "R1 code 2");
    measureCode(1'b0, 18, 1'b1, "R1 code 18");

    // R5: clamp on both instances
    measureCode(1'b0, 31, 1'b0, "R5 clamp full");
    measureCode(1'b1, 31, 1'b0, "R5 clamp limited");
    measureCode(1'b1, 17, 1'b1, "R5 code 17 limited");

    // R7: code change mid-period
    startRun(1'b0, 5'd4, 1'b0);
    runPeriod(1'b0, 2, 5'd2, a, p, g);
    check(p == 8 && a == 4, "R7 old period kept", p, 8);
    runPeriod(1'b0, 0, '0, a, p, g);
    check(p == 4 && a == 2, "R7 new period applied", p, 4);

    // R8: abort in active phase
    startRun(1'b0, 5'd6, 1'b1);
    repeat (3) @(negedge clk);
    check(sclkM != cpol, "R8 still active before abort", sclkM, !cpol);
    enable = 1'b0;
    @(negedge clk);
    check(!actM && sclkM == cpol, "R8 abort to idle", sclkM, cpol);
    expectIdle(20, "R8 stays idle after abort");

    // Random codes across and above the ladder
    for (int k = 0; k < 16; k++) begin
      int c = 2 + ($urandom % 30);
      logic pol = 1'($urandom % 2);
      measureCode(1'b0, c, pol, "R1 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule